// File: doc/BRIEF.md
# ROM Protection and Verification Controller

This block sits in front of a 16K-byte on-chip program ROM. It keeps the ROM from being read out, and it gives production test two ways to check the ROM contents. A build-time parameter decides whether the device is sealed, meaning its ROM is protected; no register can change this while the chip runs. In open-verify mode, which only works on unsealed builds, a tester drives a 14-bit address on two ports and reads the stored byte back on an 8-bit data port. On a sealed build that request is refused and the data port stays released.

Blind-verify mode works on both builds. The block steps its own address counter from zero. For each address the tester strobes in the byte it expects, and the block compares it with the stored byte. After each group of 16 compares, a status output shows whether the whole group matched, so the stored data never leaves the chip.

The block also filters code-byte reads made by the processor. When a sealed device is executing from external program memory, a read aimed at the internal ROM returns a fixed invalid byte. In this model the ROM contents come from a seeded arithmetic function, not from a stored table.

Top module: `romguard_top`

## Requirements
- R1: The byte stored at ROM address a is H xor L, where H and L are the high and low bytes of (a*40503 + ROM_SEED) mod 65536. ROM_SEED defaults to 0xA5C3, so address 0 holds 0x66 and address 1 holds 0xB9.
- R2: An open-verify request is prog_strobe_n_i=0, addr_latch_i=1, ext_fetch_i=1 and chip_reset_i=0. On an unsealed build, data_oe_o is 1 two rising edges after the request is sampled, and it drops two edges after the request ends.
- R3: While data_oe_o is 1, data_o holds the ROM byte at address {addr_hi_i, addr_lo_i} (high port = bits 13:8) as sampled two rising edges earlier.
- R4: On a sealed build (SEALED=1), data_oe_o is never 1 and data_o is always 0, whatever the mode pins do.
- R5: Whenever data_oe_o is 0, data_o is 0.
- R6: A blind-verify request is prog_strobe_n_i=1, addr_latch_i=1, ext_fetch_i=1 and chip_reset_i=0, registered once. Outside that mode the address counter and group state are held at zero, so every entry starts at address 0 and strobes given outside the mode are ignored.
- R7: Each exp_stb_i in blind-verify mode compares exp_byte_i with the ROM byte at the counter address. The counter then advances by one and wraps from 0x3FFF to 0.
- R8: On the 16th strobe of a group, pv_ok_o becomes 1 if all 16 compares of that group matched and 0 otherwise. It holds that value until the next group completes, and each group starts with no recorded mismatch.
- R9: cpu_vld_o follows cpu_rd_i one edge later. On a read edge that is not blocked, cpu_data_o takes the ROM byte at cpu_addr_i. Between reads, cpu_data_o holds its value.
- R10: A read of an address at or above 0x4000, or any read with cpu_ext_i=1 on a sealed build, returns 0xFF on cpu_data_o.
- R11: While rst_n is 0, at a rising edge, data_o=0, data_oe_o=0, pv_ok_o=0, cpu_vld_o=0 and cpu_data_o=0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_strobe_n_i | input | 1 | Program-store strobe pin level (active low) |
| addr_latch_i | input | 1 | Address-latch pin level |
| ext_fetch_i | input | 1 | External-access pin level |
| chip_reset_i | input | 1 | Chip reset pin level |
| addr_lo_i | input | 8 | Open-verify address bits 7:0 |
| addr_hi_i | input | ADDR_W-8 | Open-verify address bits 13:8 |
| data_o | output | 8 | Open-verify read data |
| data_oe_o | output | 1 | Data port drive enable |
| exp_byte_i | input | 8 | Expected byte for blind verify |
| exp_stb_i | input | 1 | Expected-byte strobe |
| pv_ok_o | output | 1 | Result of the last complete 16-byte group |
| cpu_rd_i | input | 1 | Code-byte read request |
| cpu_ext_i | input | 1 | Read issued while executing from external memory |
| cpu_addr_i | input | CPU_AW | Code read address |
| cpu_data_o | output | 8 | Code read data |
| cpu_vld_o | output | 1 | Code read data valid |

## Verification
On every cycle, the assertions check the open-read latency and address alignment. They also check that the data port is quiet when it is not driven and that a sealed build never drives it. For the blind counter they check clearing, single-step advance and wrap, and they check that status is held between group boundaries. Read valid timing and blocking of forbidden code reads are checked every cycle as well. Only the bench scenarios can show the actual ROM contents. The same goes for whether a group with a planted mismatch at its first, middle or last position reports failure, and whether a re-entered mode restarts from address 0. They also show that a wrapped counter addresses byte 0 again, which appears as a passing group only when the expected bytes start from address 0.

// File: rtl/romguard_pkg.sv
// romguard_pkg: shared types and the ROM content function.
// Assumes an 8-bit data path. The ROM is a seeded arithmetic function of the
// address, so no large array is ever built.
package romguard_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_OPEN  = 2'd1,
        MODE_BLIND = 2'd2
    } vmode_e;

    // Returns the stored byte for an address under the given seed.
    function automatic byte_t rom_cell(input logic [31:0] addr, input logic [15:0] seed);
        logic [31:0] prod;
        prod = (addr * 32'd40503) + {16'd0, seed};
        return prod[15:8] ^ prod[7:0];
    endfunction

endpackage

// File: rtl/rg_mode_decode.sv
// rg_mode_decode: registers the test-mode pin levels and decodes the active
// verify mode. Assumes the pins are already synchronous to clk. On a sealed
// build the open mode is never granted.
module rg_mode_decode
    import romguard_pkg::*;
#(
    parameter bit SEALED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_strobe_n_i,
    input  logic addr_latch_i,
    input  logic ext_fetch_i,
    input  logic chip_reset_i,
    output logic open_act_o,
    output logic blind_act_o
);

    vmode_e mode_q;
    vmode_e mode_d;
    logic   test_pins;

    // Common pin pattern shared by both verify modes.
    assign test_pins = addr_latch_i & ext_fetch_i & ~chip_reset_i;

    // Pick the requested mode from the strobe pin level.
    always_comb begin
        mode_d = MODE_RUN;
        if (test_pins && !prog_strobe_n_i) begin
            mode_d = SEALED ? MODE_RUN : MODE_OPEN;
        end else if (test_pins && prog_strobe_n_i) begin
            mode_d = MODE_BLIND;
        end
    end

    // Register the decoded mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RUN;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign open_act_o  = (mode_q == MODE_OPEN);
    assign blind_act_o = (mode_q == MODE_BLIND);

endmodule

// File: rtl/rg_open_reader.sv
// rg_open_reader: open-verify read path. Delays the external address by
// RD_LAT-1 stages, then registers the ROM byte, so data follows the address
// by RD_LAT edges. Data is forced to zero whenever the port is not enabled.
// Assumes RD_LAT >= 1.
module rg_open_reader
    import romguard_pkg::*;
#(
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned RD_LAT   = 2,
    parameter logic [15:0] ROM_SEED = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_act_i,
    input  logic [ADDR_W-1:0] addr_i,
    output byte_t             data_o,
    output logic              oe_o
);

    localparam int unsigned STAGES = RD_LAT - 1;

    logic [ADDR_W-1:0] tail_addr;
    byte_t             data_q;
    logic              oe_q;

    generate
        if (STAGES == 0) begin : g_direct
            assign tail_addr = addr_i;
        end else begin : g_pipe
            logic [ADDR_W-1:0] stg_q [STAGES];

            // Shift the sampled address through the delay stages.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
                end else begin
                    stg_q[0] <= addr_i;
                    for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
                end
            end

            assign tail_addr = stg_q[STAGES-1];
        end
    endgenerate

    // Fetch the byte and the enable, zero whenever the mode is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            oe_q   <= 1'b0;
        end else begin
            data_q <= open_act_i ? rom_cell(32'(tail_addr), ROM_SEED) : '0;
            oe_q   <= open_act_i;
        end
    end

    assign data_o = data_q;
    assign oe_o   = oe_q;

endmodule

// File: rtl/rg_blind_check.sv
// rg_blind_check: blind-verify sequencer. It walks an internal address, compares
// each strobed expected byte with the stored one, and publishes a pass flag at
// every GROUP_LEN-th strobe. Assumes the ROM spans 2**ADDR_W bytes and that
// the state is cleared whenever the mode is off.
module rg_blind_check
    import romguard_pkg::*;
#(
    parameter int unsigned ADDR_W    = 14,
    parameter int unsigned GROUP_LEN = 16,
    parameter logic [15:0] ROM_SEED  = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blind_act_i,
    input  logic              stb_i,
    input  byte_t             exp_i,
    output logic              ok_o,
    output logic [ADDR_W-1:0] cnt_o,
    output logic              group_end_o
);

    localparam int unsigned BEAT_W = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;
    localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(GROUP_LEN - 1);
    localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

    logic [ADDR_W-1:0] cnt_q;
    logic [BEAT_W-1:0] beat_q;
    logic              sticky_q;
    logic              ok_q;
    logic              mism;
    logic              take;

    // Compare the strobed byte with the stored byte at the current address.
    assign mism = (rom_cell(32'(cnt_q), ROM_SEED) != exp_i);
    assign take = blind_act_i & stb_i;

    // Step the address, track the group, and publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            beat_q   <= '0;
            sticky_q <= 1'b0;
            ok_q     <= 1'b0;
        end else if (!blind_act_i) begin
            cnt_q    <= '0;
            beat_q   <= '0;
            sticky_q <= 1'b0;
        end else if (stb_i) begin
            cnt_q <= (cnt_q == ADDR_LAST) ? '0 : cnt_q + 1'b1;
            if (beat_q == BEAT_LAST) begin
                ok_q     <= ~(sticky_q | mism);
                sticky_q <= 1'b0;
                beat_q   <= '0;
            end else begin
                beat_q   <= beat_q + 1'b1;
                sticky_q <= sticky_q | mism;
            end
        end
    end

    assign ok_o        = ok_q;
    assign cnt_o       = cnt_q;
    assign group_end_o = take & (beat_q == BEAT_LAST);

endmodule

// File: rtl/rg_fetch_guard.sv
// rg_fetch_guard: code-read filter. It returns the ROM byte one edge after a
// read, unless the address lies outside the ROM or a sealed build is reading
// while executing externally; those reads return BAD_BYTE.
// Assumes CPU_AW > ADDR_W.
module rg_fetch_guard
    import romguard_pkg::*;
#(
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned CPU_AW   = 16,
    parameter bit          SEALED   = 1'b0,
    parameter logic [15:0] ROM_SEED = 16'hA5C3,
    parameter byte_t       BAD_BYTE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              ext_i,
    input  logic [CPU_AW-1:0] addr_i,
    output byte_t             data_o,
    output logic              vld_o
);

    logic  in_rom;
    logic  blocked;
    byte_t data_q;
    logic  vld_q;

    // Decide whether this read may see ROM content.
    assign in_rom  = (addr_i[CPU_AW-1:ADDR_W] == '0);
    assign blocked = ~in_rom | (SEALED & ext_i);

    // Register the returned byte and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= BAD_BYTE;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= rd_i;
            if (rd_i) begin
                data_q <= blocked ? BAD_BYTE
                                  : rom_cell(32'(addr_i[ADDR_W-1:0]), ROM_SEED);
            end
        end
    end

    assign data_o = data_q;
    assign vld_o  = vld_q;

endmodule

// File: rtl/romguard_top.sv
// romguard_top: ROM protection and verification controller. It ties the mode
// decoder, the open-verify reader, the blind-verify sequencer and the
// code-read filter together. SEALED fixes protection at build time.
// Assumes all inputs are synchronous to clk.
module romguard_top
    import romguard_pkg::*;
#(
    parameter int unsigned ADDR_W    = 14,
    parameter int unsigned CPU_AW    = 16,
    parameter int unsigned GROUP_LEN = 16,
    parameter int unsigned RD_LAT    = 2,
    parameter bit          SEALED    = 1'b0,
    parameter logic [15:0] ROM_SEED  = 16'hA5C3,
    parameter logic [7:0]  BAD_BYTE  = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_strobe_n_i,
    input  logic              addr_latch_i,
    input  logic              ext_fetch_i,
    input  logic              chip_reset_i,
    input  logic [7:0]        addr_lo_i,
    input  logic [ADDR_W-9:0] addr_hi_i,
    output logic [7:0]        data_o,
    output logic              data_oe_o,
    input  logic [7:0]        exp_byte_i,
    input  logic              exp_stb_i,
    output logic              pv_ok_o,
    input  logic              cpu_rd_i,
    input  logic              cpu_ext_i,
    input  logic [CPU_AW-1:0] cpu_addr_i,
    output logic [7:0]        cpu_data_o,
    output logic              cpu_vld_o
);

    logic              open_act;
    logic              blind_act;
    logic [ADDR_W-1:0] blind_cnt;
    logic              group_end;

    rg_mode_decode #(
        .SEALED(SEALED)
    ) u_mode (
        .clk            (clk),
        .rst_n          (rst_n),
        .prog_strobe_n_i(prog_strobe_n_i),
        .addr_latch_i   (addr_latch_i),
        .ext_fetch_i    (ext_fetch_i),
        .chip_reset_i   (chip_reset_i),
        .open_act_o     (open_act),
        .blind_act_o    (blind_act)
    );

    rg_open_reader #(
        .ADDR_W  (ADDR_W),
        .RD_LAT  (RD_LAT),
        .ROM_SEED(ROM_SEED)
    ) u_open (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_act_i(open_act),
        .addr_i    ({addr_hi_i, addr_lo_i}),
        .data_o    (data_o),
        .oe_o      (data_oe_o)
    );

    rg_blind_check #(
        .ADDR_W   (ADDR_W),
        .GROUP_LEN(GROUP_LEN),
        .ROM_SEED (ROM_SEED)
    ) u_blind (
        .clk        (clk),
        .rst_n      (rst_n),
        .blind_act_i(blind_act),
        .stb_i      (exp_stb_i),
        .exp_i      (exp_byte_i),
        .ok_o       (pv_ok_o),
        .cnt_o      (blind_cnt),
        .group_end_o(group_end)
    );

    rg_fetch_guard #(
        .ADDR_W  (ADDR_W),
        .CPU_AW  (CPU_AW),
        .SEALED  (SEALED),
        .ROM_SEED(ROM_SEED),
        .BAD_BYTE(BAD_BYTE)
    ) u_fetch (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_i  (cpu_rd_i),
        .ext_i (cpu_ext_i),
        .addr_i(cpu_addr_i),
        .data_o(cpu_data_o),
        .vld_o (cpu_vld_o)
    );

endmodule

// File: rtl/romguard_sva.sv
// romguard_sva: checker bound to romguard_top. It watches the ports together
// with the blind sequencer's counter, its group-end strobe and its mode flag.
module romguard_sva
    import romguard_pkg::*;
#(
    parameter int unsigned ADDR_W    = 14,
    parameter int unsigned CPU_AW    = 16,
    parameter bit          SEALED    = 1'b0,
    parameter logic [15:0] ROM_SEED  = 16'hA5C3,
    parameter logic [7:0]  BAD_BYTE  = 8'hFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_strobe_n_i,
    input logic              addr_latch_i,
    input logic              ext_fetch_i,
    input logic              chip_reset_i,
    input logic [ADDR_W-1:0] vaddr,
    input logic [7:0]        data_o,
    input logic              data_oe_o,
    input logic              exp_stb_i,
    input logic              pv_ok_o,
    input logic              blind_act,
    input logic [ADDR_W-1:0] blind_cnt,
    input logic              group_end,
    input logic              cpu_rd_i,
    input logic              cpu_ext_i,
    input logic [CPU_AW-1:0] cpu_addr_i,
    input logic [7:0]        cpu_data_o,
    input logic              cpu_vld_o
);

    localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

    logic open_pins;
    assign open_pins = !prog_strobe_n_i && addr_latch_i && ext_fetch_i && !chip_reset_i;

    // R2: an open request on an unsealed build drives the port two edges later
    a_r2_open_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (open_pins && !SEALED) |=> ##1 data_oe_o);

    // R3: driven data matches the address sampled two edges earlier
    a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> (data_o == rom_cell(32'($past(vaddr, 2)), ROM_SEED)));

    // R4: a sealed build never drives the port
    a_r4_sealed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(SEALED && data_oe_o));

    // R5: an undriven port carries zero
    a_r5_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe_o |-> (data_o == 8'h00));

    // R6: outside blind mode the counter is at zero
    a_r6_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !blind_act |=> (blind_cnt == '0));

    // R7: a strobe at the last address wraps to zero
    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (blind_act && exp_stb_i && blind_cnt == ADDR_LAST) |=> (blind_cnt == '0));

    // R7: a strobe below the last address steps by one
    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        (blind_act && exp_stb_i && blind_cnt != ADDR_LAST)
            |=> (blind_cnt == $past(blind_cnt) + 1'b1));

    // R8: status only moves at a group boundary
    a_r8_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !group_end |=> $stable(pv_ok_o));

    // R9: valid follows the read request by one edge
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd_i |=> cpu_vld_o);

    a_r9_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd_i |=> !cpu_vld_o);

    // R10: forbidden reads return the invalid byte
    a_r10_blocked_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_i && ((SEALED && cpu_ext_i) || (cpu_addr_i[CPU_AW-1:ADDR_W] != '0)))
            |=> (cpu_data_o == BAD_BYTE));

endmodule

bind romguard_top romguard_sva #(
    .ADDR_W  (ADDR_W),
    .CPU_AW  (CPU_AW),
    .SEALED  (SEALED),
    .ROM_SEED(ROM_SEED),
    .BAD_BYTE(BAD_BYTE)
) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .prog_strobe_n_i(prog_strobe_n_i),
    .addr_latch_i   (addr_latch_i),
    .ext_fetch_i    (ext_fetch_i),
    .chip_reset_i   (chip_reset_i),
    .vaddr          ({addr_hi_i, addr_lo_i}),
    .data_o         (data_o),
    .data_oe_o      (data_oe_o),
    .exp_stb_i      (exp_stb_i),
    .pv_ok_o        (pv_ok_o),
    .blind_act      (blind_act),
    .blind_cnt      (blind_cnt),
    .group_end      (group_end),
    .cpu_rd_i       (cpu_rd_i),
    .cpu_ext_i      (cpu_ext_i),
    .cpu_addr_i     (cpu_addr_i),
    .cpu_data_o     (cpu_data_o),
    .cpu_vld_o      (cpu_vld_o)
);

// File: tb/romguard_top_bench.sv
// romguard_top_bench: drives an unsealed and a sealed instance with the same
// stimulus and compares both against a behavioural model on every clock.
module romguard_top_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        prog_n = 1'b1, latch = 1'b0, extsel = 1'b0, chiprst = 1'b1;
    logic [7:0]  alo = 8'h00;
    logic [5:0]  ahi = 6'h00;
    logic [7:0]  exp_b = 8'h00;
    logic        stb = 1'b0;
    logic        crd = 1'b0, cext = 1'b0;
    logic [15:0] caddr = 16'h0000;

    logic [1:0][7:0] o_data, o_cdata;
    logic [1:0]      o_oe, o_ok, o_cvld;

    romguard_top #(.SEALED(1'b0)) u_romguard_top (
        .clk(clk), .rst_n(rst_n), .prog_strobe_n_i(prog_n), .addr_latch_i(latch),
        .ext_fetch_i(extsel), .chip_reset_i(chiprst), .addr_lo_i(alo), .addr_hi_i(ahi),
        .data_o(o_data[0]), .data_oe_o(o_oe[0]), .exp_byte_i(exp_b), .exp_stb_i(stb),
        .pv_ok_o(o_ok[0]), .cpu_rd_i(crd), .cpu_ext_i(cext), .cpu_addr_i(caddr),
        .cpu_data_o(o_cdata[0]), .cpu_vld_o(o_cvld[0]));

    romguard_top #(.SEALED(1'b1)) u_romguard_top_sealed (
        .clk(clk), .rst_n(rst_n), .prog_strobe_n_i(prog_n), .addr_latch_i(latch),
        .ext_fetch_i(extsel), .chip_reset_i(chiprst), .addr_lo_i(alo), .addr_hi_i(ahi),
        .data_o(o_data[1]), .data_oe_o(o_oe[1]), .exp_byte_i(exp_b), .exp_stb_i(stb),
        .pv_ok_o(o_ok[1]), .cpu_rd_i(crd), .cpu_ext_i(cext), .cpu_addr_i(caddr),
        .cpu_data_o(o_cdata[1]), .cpu_vld_o(o_cvld[1]));

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // R1 content formula, written from the requirement
    function automatic int ref_rom(input longint a);
        longint p;
        p = (a * 40503 + 'hA5C3) % 65536;
        return int'(((p >> 8) ^ p) & 'hFF);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, expv);
        end
    endtask

    // Behavioural model state, one set per instance (index 1 = sealed)
    int m_a[2], m_d[2], m_cnt[2], m_beat[2], m_cd[2];
    bit m_oe[2], m_open[2], m_blind[2], m_sticky[2], m_ok[2], m_cv[2], m_blk[2];

    always @(posedge clk) begin
        for (int d = 0; d < 2; d++) begin
            if (!rst_n) begin
                m_a[d] = 0; m_d[d] = 0; m_oe[d] = 0; m_open[d] = 0; m_blind[d] = 0;
                m_cnt[d] = 0; m_beat[d] = 0; m_sticky[d] = 0; m_ok[d] = 0;
                m_cv[d] = 0; m_cd[d] = 'hFF; m_blk[d] = 0;
            end else begin
                bit tp;
                m_d[d]  = m_open[d] ? ref_rom(m_a[d]) : 0;
                m_oe[d] = m_open[d];
                m_a[d]  = {ahi, alo};
                if (!m_blind[d]) begin
                    m_cnt[d] = 0; m_beat[d] = 0; m_sticky[d] = 0;
                end else if (stb) begin
                    bit mm;
                    mm = (ref_rom(m_cnt[d]) != int'(exp_b));
                    if (m_beat[d] == 15) begin
                        m_ok[d] = !(m_sticky[d] || mm);
                        m_sticky[d] = 0; m_beat[d] = 0;
                    end else begin
                        m_beat[d]++;
                        m_sticky[d] = m_sticky[d] || mm;
                    end
                    m_cnt[d] = (m_cnt[d] + 1) % 16384;
                end
                tp = latch && extsel && !chiprst;
                m_open[d]  = tp && !prog_n && (d == 0);
                m_blind[d] = tp && prog_n;
                m_cv[d] = crd;
                if (crd) begin
                    m_blk[d] = (d == 1 && cext) || (caddr >= 16'h4000);
                    m_cd[d]  = m_blk[d] ? 'hFF : ref_rom(caddr);
                end
            end
        end
    end

    // Compare every output of both instances with the model away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int d = 0; d < 2; d++) begin
                chk(d == 1 ? "R4" : "R2", "data_oe_o", int'(o_oe[d]), int'(m_oe[d]));
                chk(d == 1 ? "R4" : (m_oe[d] ? "R3" : "R5"), "data_o", int'(o_data[d]), m_d[d]);
                chk("R8", "pv_ok_o", int'(o_ok[d]), int'(m_ok[d]));
                chk("R9", "cpu_vld_o", int'(o_cvld[d]), int'(m_cv[d]));
                chk(m_blk[d] ? "R10" : "R9", "cpu_data_o", int'(o_cdata[d]), m_cd[d]);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // 0 = none, 1 = open verify, 2 = blind verify
    task automatic set_mode(input int md);
        latch = 1'b1; extsel = 1'b1;
        chiprst = (md == 0);
        prog_n  = (md != 1);
    endtask

    int sa = 0;

    // One group of 16 expected bytes; err_pos < 0 means all correct
    task automatic send_group(input int err_pos, input bit gaps);
        for (int i = 0; i < 16; i++) begin
            exp_b = 8'(ref_rom(sa) ^ ((i == err_pos) ? 'h10 : 0));
            stb = 1'b1;
            sa = (sa + 1) % 16384;
            @(negedge clk);
            if (gaps && (i % 3 == 1)) begin
                stb = 1'b0;
                @(negedge clk);
            end
        end
        stb = 1'b0;
    endtask

    initial begin
        int lcg;
        lcg = 12345;
        cyc(3);
        // R11: reset state
        for (int d = 0; d < 2; d++) begin
            chk("R11", "data_o", int'(o_data[d]), 0);
            chk("R11", "data_oe_o", int'(o_oe[d]), 0);
            chk("R11", "pv_ok_o", int'(o_ok[d]), 0);
            chk("R11", "cpu_vld_o", int'(o_cvld[d]), 0);
            chk("R11", "cpu_data_o", int'(o_cdata[d]), 'hFF);
        end
        rst_n = 1'b1;
        cyc(2);

        // Open verify, fixed addresses (R1, R2, R4)
        set_mode(1); alo = 8'h00; ahi = 6'h00;
        cyc(4);
        chk("R1", "rom[0]", int'(o_data[0]), 'h66);
        chk("R2", "oe on", int'(o_oe[0]), 1);
        chk("R4", "sealed oe", int'(o_oe[1]), 0);
        alo = 8'h01;
        cyc(2);
        chk("R1", "rom[1]", int'(o_data[0]), 'hB9);
        alo = 8'hFF; ahi = 6'h3F;
        cyc(1);
        // Open verify, changing address every cycle (R3)
        for (int i = 0; i < 300; i++) begin
            lcg = lcg * 1103515245 + 12345;
            {ahi, alo} = 14'(lcg >>> 8);
            cyc(1);
        end
        // Leave the mode (R5)
        set_mode(0);
        cyc(3);
        chk("R5", "data off", int'(o_data[0]), 0);
        chk("R2", "oe off", int'(o_oe[0]), 0);

        // Blind verify groups (R8)
        set_mode(2); sa = 0;
        cyc(1);
        send_group(-1, 1'b0);
        chk("R8", "clean group", int'(o_ok[0]), 1);
        send_group(7, 1'b1);
        chk("R8", "middle miss", int'(o_ok[0]), 0);
        send_group(-1, 1'b1);
        chk("R8", "sticky cleared", int'(o_ok[1]), 1);
        send_group(15, 1'b0);
        chk("R8", "last miss", int'(o_ok[0]), 0);
        send_group(0, 1'b0);
        chk("R8", "first miss", int'(o_ok[1]), 0);
        // Strobes outside the mode, then re-entry (R6)
        set_mode(0);
        cyc(2);
        for (int i = 0; i < 5; i++) begin
            stb = 1'b1; exp_b = 8'h00;
            cyc(1);
        end
        stb = 1'b0;
        set_mode(2); sa = 0;
        cyc(1);
        send_group(-1, 1'b0);
        chk("R6", "restart at 0", int'(o_ok[0]), 1);
        chk("R6", "restart at 0 sealed", int'(o_ok[1]), 1);
        // Walk to the top of the ROM, last group failing, then wrap (R7)
        for (int g = 1; g < 1023; g++) send_group(-1, 1'b0);
        send_group(9, 1'b0);
        chk("R7", "pre-wrap miss", int'(o_ok[0]), 0);
        send_group(-1, 1'b0);
        chk("R7", "wrapped to 0", int'(o_ok[0]), 1);
        chk("R7", "wrapped to 0 sealed", int'(o_ok[1]), 1);
        set_mode(0);

        // Code reads (R9, R10)
        crd = 1'b1; cext = 1'b1; caddr = 16'h0005;
        cyc(1);
        chk("R9", "open build read", int'(o_cdata[0]), ref_rom(5));
        chk("R10", "sealed ext read", int'(o_cdata[1]), 'hFF);
        cext = 1'b0; caddr = 16'h4000;
        cyc(1);
        chk("R10", "beyond rom", int'(o_cdata[0]), 'hFF);
        cext = 1'b0; caddr = 16'h3FFF;
        cyc(1);
        chk("R9", "sealed internal read", int'(o_cdata[1]), ref_rom('h3FFF));
        for (int i = 0; i < 400; i++) begin
            lcg = lcg * 1103515245 + 12345;
            crd  = lcg[20];
            cext = lcg[21];
            caddr = lcg[22] ? 16'(lcg >>> 4) : {2'b00, 14'(lcg >>> 6)};
            cyc(1);
        end
        crd = 1'b0;
        cyc(3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule